// File: doc/BRIEF.md
# Serial Bus Idle Gap Detector

This block watches the single shared line of a wired-AND style serial bus and measures how long the line has stayed released. The measure is a count of arbitration clock periods. It sorts the current idle stretch into three nested gap classes, from shortest to longest: acknowledge, subaction and arbitration reset. The arbitration reset gap opens a new fairness interval, and asynchronous traffic follows it.

Each class has two limits. The first is a detect point, where the node recognises the gap. The second, later point is the earliest cycle at which any node may drive the line again. A node therefore always sees a gap before another node can legally end it. The node names the gap it is waiting for. Once the idle count reaches that gap's full assert length, the block grants permission to drive at once. Every sample of the line as driven clears the count. The count saturates rather than wrapping around, and the line passes through a synchronizer before it is counted.

Top module: `idle_gap_monitor`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `gap_det`, `fair_start` and `may_drive` are all 0. Reset treats the line as driven.
- R2: `bus_line` is high when driven and low when released. It passes through two synchronizer flops. After `bus_line` has been sampled low on m consecutive rising edges, the idle count equals m-2 (minimum 0).
- R3: A single rising edge that samples `bus_line` high clears the idle count. All gap flags are low from the second edge after that sample.
- R4: The idle count saturates at 2^CNT_W-1, which is 63 by default. During an arbitrarily long idle stretch, every flag that has risen stays high.
- R5: `gap_det[0]` (acknowledge) is high exactly when the idle count is at least 4. `gap_det[1]` (subaction) is high exactly when it is at least 12. `gap_det[2]` (arbitration reset) is high exactly when it is at least 28.
- R6: `gap_det` is always thermometer coded: a longer gap flag is never high without every shorter one.
- R7: `fair_start` is a one-cycle pulse in the first cycle of an idle stretch in which `gap_det[2]` is high.
- R8: `wait_gap` encodes the awaited gap: 1 is acknowledge, 2 is subaction, 3 is arbitration reset. `may_drive` is high exactly when the idle count is at least that gap's assert length: 6, 16 or 32 respectively.
- R9: With `wait_gap` = 0 (nothing awaited), `may_drive` stays low whatever the idle count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Arbitration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_line | input | 1 | Sampled bus level, 1 = driven |
| wait_gap | input | 2 | Awaited gap: 0 none, 1 ack, 2 subaction, 3 arbitration reset |
| gap_det | output | 3 | Detect flags: bit 0 ack, bit 1 subaction, bit 2 arbitration reset |
| fair_start | output | 1 | One-cycle pulse at the start of a fairness interval |
| may_drive | output | 1 | Permission to drive the bus for the awaited gap |

## Verification
The bench sweeps every idle stretch length from 0 to 40 under each `wait_gap` value, with driven pulses of varying width between stretches. This places every detect and assert limit both one cycle before and exactly on its boundary. An off-by-one in a comparator, or a synchronizer one flop short or long, shifts a flag by a cycle, and the per-cycle comparison catches it. A long idle run exposes a counter that wraps, because its flags would drop out after 64 cycles. A short driven blip after a long idle shows whether the clear works and lands on the right cycle. Repeated arbitration reset gaps confirm that `fair_start` fires exactly once per stretch, and not on every saturated cycle.

// File: rtl/gapmon_pkg.sv
package gapmon_pkg;

   localparam int unsigned NUM_GAPS = 3;

   // awaited-gap selector; value n (n>0) maps to gap index n-1
   typedef enum logic [1:0] {
      WAIT_NONE = 2'd0,
      WAIT_ACK  = 2'd1,
      WAIT_SUB  = 2'd2,
      WAIT_ARB  = 2'd3
   } wait_sel_e;

   localparam int unsigned IDX_ACK = 0;
   localparam int unsigned IDX_SUB = 1;
   localparam int unsigned IDX_ARB = 2;

endpackage

// File: rtl/gapmon_sync.sv
module gapmon_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);

   initial begin
      assert (STAGES >= 1) else $error("gapmon_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= RESET_VAL;
               else        chain_q[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= RESET_VAL;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/gapmon_idle_ctr.sv
module gapmon_idle_ctr #(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy,
   output logic [CNT_W-1:0] idle_cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   initial begin
      assert (CNT_W >= 2) else $error("gapmon_idle_ctr: CNT_W too small");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      if (busy)                 cnt_d = '0;
      else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
      else                      cnt_d = cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign idle_cnt = cnt_q;

   a_r3_clear_on_drive: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (idle_cnt == '0));

   a_r4_hold_at_max: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && idle_cnt == CNT_MAX) |=> (idle_cnt == CNT_MAX));

   a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && idle_cnt != CNT_MAX) |=> (idle_cnt == $past(idle_cnt) + CNT_W'(1)));

endmodule

// File: rtl/gapmon_thresh.sv
module gapmon_thresh #(
   parameter int unsigned CNT_W = 6,
   parameter int unsigned DET   = 4,
   parameter int unsigned ASR   = 6
) (
   input  logic [CNT_W-1:0] idle_cnt,
   output logic             det,
   output logic             asr_ok
);

   localparam logic [CNT_W-1:0] DET_V = CNT_W'(DET);
   localparam logic [CNT_W-1:0] ASR_V = CNT_W'(ASR);

   initial begin
      assert (DET < ASR) else $error("gapmon_thresh: detect limit must precede assert limit");
      assert (ASR < (1 << CNT_W) - 1) else $error("gapmon_thresh: assert limit must sit below counter ceiling");
      assert (DET >= 1) else $error("gapmon_thresh: detect limit must be nonzero");
   end

   always_comb begin
      det    = (idle_cnt >= DET_V);
      asr_ok = (idle_cnt >= ASR_V);
   end

endmodule

// File: rtl/idle_gap_monitor.sv
module idle_gap_monitor
   import gapmon_pkg::*;
#(
   parameter int unsigned CNT_W       = 6,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ACK_DET     = 4,
   parameter int unsigned ACK_ASR     = 6,
   parameter int unsigned SUB_DET     = 12,
   parameter int unsigned SUB_ASR     = 16,
   parameter int unsigned ARB_DET     = 28,
   parameter int unsigned ARB_ASR     = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_line,
   input  logic [1:0] wait_gap,
   output logic [2:0] gap_det,
   output logic       fair_start,
   output logic       may_drive
);

   localparam int unsigned DET_TAB [NUM_GAPS] = '{ACK_DET, SUB_DET, ARB_DET};
   localparam int unsigned ASR_TAB [NUM_GAPS] = '{ACK_ASR, SUB_ASR, ARB_ASR};

   initial begin
      assert (ACK_DET < SUB_DET && SUB_DET < ARB_DET)
         else $error("idle_gap_monitor: detect limits must grow with gap length");
      assert (ACK_ASR < SUB_ASR && SUB_ASR < ARB_ASR)
         else $error("idle_gap_monitor: assert limits must grow with gap length");
   end

   logic             bus_sync;
   logic [CNT_W-1:0] idle_cnt;
   logic [NUM_GAPS-1:0] det_vec;
   logic [NUM_GAPS-1:0] asr_vec;
   logic             arb_seen_q;

   gapmon_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (bus_line),
      .d_out (bus_sync)
   );

   gapmon_idle_ctr #(
      .CNT_W (CNT_W)
   ) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy     (bus_sync),
      .idle_cnt (idle_cnt)
   );

   generate
      for (genvar g = 0; g < NUM_GAPS; g++) begin : g_gap
         gapmon_thresh #(
            .CNT_W (CNT_W),
            .DET   (DET_TAB[g]),
            .ASR   (ASR_TAB[g])
         ) u_thr (
            .idle_cnt (idle_cnt),
            .det      (det_vec[g]),
            .asr_ok   (asr_vec[g])
         );

         a_r8_permit_after_detect: assert property (@(posedge clk) disable iff (!rst_n)
            asr_vec[g] |-> det_vec[g]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) arb_seen_q <= 1'b0;
      else        arb_seen_q <= det_vec[IDX_ARB];
   end

   always_comb begin
      case (wait_gap)
         WAIT_ACK: may_drive = asr_vec[IDX_ACK];
         WAIT_SUB: may_drive = asr_vec[IDX_SUB];
         WAIT_ARB: may_drive = asr_vec[IDX_ARB];
         default:  may_drive = 1'b0;
      endcase
   end

   assign gap_det    = det_vec;
   assign fair_start = det_vec[IDX_ARB] & ~arb_seen_q;

   a_r6_nested_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_det[2] |-> gap_det[1]) and (gap_det[1] |-> gap_det[0]));

   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fair_start |=> !fair_start);

   a_r7_pulse_with_detect: assert property (@(posedge clk) disable iff (!rst_n)
      fair_start |-> gap_det[2]);

   a_r9_no_wait_no_permit: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_gap == WAIT_NONE) |-> !may_drive);

   a_r8_arb_permit_implies_detect: assert property (@(posedge clk) disable iff (!rst_n)
      (may_drive && wait_gap == WAIT_ARB) |-> gap_det[2]);

endmodule

// File: tb/idle_gap_monitor_test.sv
`timescale 1ns/1ps
module idle_gap_monitor_test;

   localparam int CMAX = 63;
   localparam int D_ACK = 4,  D_SUB = 12, D_ARB = 28;
   localparam int A_ACK = 6,  A_SUB = 16, A_ARB = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_line = 1'b1;
   logic [1:0] wait_gap = 2'd0;
   logic [2:0] gap_det;
   logic       fair_start;
   logic       may_drive;

   int n_checks = 0;
   int n_fail = 0;

   // requirement model state
   int   m_cnt = 0;
   logic m_d1 = 1'b1, m_d2 = 1'b1;
   logic m_fair = 1'b0;
   string det_tag = "R5";

   always #4 clk = ~clk;

   idle_gap_monitor uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_line   (bus_line),
      .wait_gap   (wait_gap),
      .gap_det    (gap_det),
      .fair_start (fair_start),
      .may_drive  (may_drive)
   );

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
   endtask

   task automatic cmp(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d (idle=%0d wait=%0d)", tag, act, exp, m_cnt, wait_gap);
      end
   endtask

   task automatic check_outputs();
      logic [2:0] e_det;
      int lim;
      logic e_may;
      e_det = {m_cnt >= D_ARB, m_cnt >= D_SUB, m_cnt >= D_ACK};
      case (wait_gap)
         2'd1: lim = A_ACK;
         2'd2: lim = A_SUB;
         2'd3: lim = A_ARB;
         default: lim = -1;
      endcase
      e_may = (lim >= 0) && (m_cnt >= lim);
      cmp(det_tag, gap_det, e_det);
      cmp("R6", (gap_det == 3'b000 || gap_det == 3'b001 || gap_det == 3'b011 || gap_det == 3'b111), 1);
      cmp("R7", fair_start, m_fair);
      if (wait_gap == 2'd0) cmp("R9", may_drive, 0);
      else                  cmp("R8", may_drive, e_may);
   endtask

   // one clock: drive at negedge, update model after edge, check at next negedge
   task automatic step(input logic b);
      logic prev_arb;
      bus_line = b;
      @(posedge clk);
      #1;
      prev_arb = (m_cnt >= D_ARB);
      if (m_d2) m_cnt = 0;
      else if (m_cnt < CMAX) m_cnt = m_cnt + 1;
      m_d2 = m_d1;
      m_d1 = b;
      m_fair = (m_cnt >= D_ARB) && !prev_arb;
      @(negedge clk);
      check_outputs();
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      bus_line = 1'b0;
      @(posedge clk);
      @(negedge clk);
      cmp("R1", gap_det, 0);
      cmp("R1", fair_start, 0);
      cmp("R1", may_drive, 0);
      m_cnt = 0; m_d1 = 1'b1; m_d2 = 1'b1; m_fair = 1'b0;
      rst_n = 1'b1;
      wait_gap = 2'd3;
      step(1'b0);
      cmp("R1", gap_det, 0);
      cmp("R1", may_drive, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();

      // R2: synchronizer latency at the first detect boundary
      step(1'b1);
      wait_gap = 2'd1;
      det_tag = "R2";
      for (int i = 0; i < 8; i++) step(1'b0);
      det_tag = "R5";

      // main sweep: every idle length 0..40 under each awaited gap
      for (int w = 0; w < 4; w++) begin
         wait_gap = w[1:0];
         for (int len = 0; len <= 40; len++) begin
            for (int p = 0; p <= len % 3; p++) step(1'b1);
            for (int i = 0; i < len; i++) step(1'b0);
         end
      end

      // R4: long idle must not wrap the flags off
      wait_gap = 2'd3;
      step(1'b1);
      det_tag = "R4";
      for (int i = 0; i < 120; i++) step(1'b0);
      cmp("R4", gap_det, 7);
      cmp("R4", may_drive, 1);

      // R3: single driven blip after a saturated idle run
      det_tag = "R3";
      step(1'b1);
      cmp("R3", gap_det, 7);
      step(1'b0);
      cmp("R3", gap_det, 7);
      step(1'b0);
      cmp("R3", gap_det, 0);
      for (int i = 0; i < 35; i++) step(1'b0);
      det_tag = "R5";

      // R1: reset in the middle of an idle stretch
      do_reset();
      for (int i = 0; i < 10; i++) step(1'b0);

      summary();
      $finish;
   end

endmodule